// File: doc/BRIEF.md
# Debounced modem-line change reporter

This block watches a set of slow, general-purpose modem status inputs, such as clear-to-send and carrier-detect. It accepts a new level on a line only after two samples in a row have shown it, and then reports the line to the host. The block runs from the system clock alone. A programmable prescaler divides that clock into a periodic sampling tick, which is 8 ms in normal use. Because nothing depends on the serial bit clocks, detection keeps working while the transmit and receive clocks are stopped.

Each raw input first passes through a two-flop synchronizer. On every tick, a per-line filter compares the sample with the line's confirmed level. A level that differs once makes the line suspect. If the next tick still shows that level, the change is confirmed and the confirmed level is updated. Confirmed changes are turned into one-cycle events, each carrying the line index and the new level. Events are reported only while the reporting enable is high. A read command returns the confirmed level of every line at any time, whether or not reporting is enabled.

Top module: `modem_line_watch`

## Requirements
- R1: While reset is asserted and after it is released, `evt_valid_o` and `rd_valid_o` are low. The confirmed levels read back as all zeros until the first sampling tick.
- R2: A sampling tick occurs every `tick_div_i`+1 system clock cycles, and confirmed levels change only on a tick. A smaller `tick_div_i` therefore shortens the time needed to confirm a change.
- R3: The first tick after reset loads every confirmed level from the synchronized inputs and raises no event.
- R4: A level that differs from the confirmed level is accepted only when two successive ticks both show it. No event appears before the second of those ticks.
- R5: A level seen on only one tick and then gone is rejected: no event is raised and the confirmed level is unchanged.
- R6: Each accepted change produces exactly one event, a single cycle with `evt_valid_o` high. `evt_idx_o` carries the line number, counted from bit 0 of `line_i`, and `evt_level_o` carries the new level.
- R7: When several lines are accepted on the same tick, their events come out one per cycle, lowest line number first.
- R8: While `report_en_i` is low, no event is raised and queued events are dropped, but confirmed levels keep tracking the inputs. Setting `report_en_i` high again does not replay changes that were missed.
- R9: One cycle after `rd_req_i` is high, `rd_valid_o` is high for that one cycle, and `rd_level_o` holds the confirmed level of every line, with bit i belonging to line i. This works regardless of `report_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | NUM_LINES | Raw modem status inputs, asynchronous |
| tick_div_i | input | CNT_W | Sampling tick period minus one, in system clock cycles |
| report_en_i | input | 1 | Enables change-event reporting |
| rd_req_i | input | 1 | Read command for the confirmed levels |
| rd_valid_o | output | 1 | Read response strobe |
| rd_level_o | output | NUM_LINES | Confirmed levels for the read response |
| evt_valid_o | output | 1 | One-cycle change event |
| evt_idx_o | output | IDX_W | Line number of the event |
| evt_level_o | output | 1 | New confirmed level of that line |

## Verification
Several input patterns are used, and each tells a different behaviour apart:

- A lasting single-line change separates a correct two-sample filter from one that accepts on the first sample, because the bench checks that no event has appeared one tick period after the change.
- A pulse held for exactly one tick period separates real debouncing from plain edge detection.
- A simultaneous change on two lines exposes ordering and lost-event faults in the event arbiter.
- Changes made while reporting is disabled, with reads issued afterwards, show that level tracking and reporting are decoupled.
- Shortening the tick period shows that the prescaler setting really governs the time to confirm a change.

// File: rtl/mlw_pkg.sv
`timescale 1ns/1ps
package mlw_pkg;
  typedef enum logic [1:0] {
    FLT_BOOT    = 2'd0,
    FLT_STEADY  = 2'd1,
    FLT_SUSPECT = 2'd2
  } flt_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mlw_sync.sv
`timescale 1ns/1ps
module mlw_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/mlw_tick.sv
`timescale 1ns/1ps
module mlw_tick #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  // >= so that lowering div_i mid-count cannot overrun the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  a_r2_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && div_i != '0 && $stable(div_i)) |=> !tick_q);
endmodule

// File: rtl/mlw_filter.sv
`timescale 1ns/1ps
module mlw_filter
  import mlw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic smp_i,
  output logic level_o,
  output logic confirm_o
);
  flt_state_e state_q;
  logic       level_q, confirm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FLT_BOOT;
      level_q   <= 1'b0;
      confirm_q <= 1'b0;
    end else begin
      confirm_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          FLT_BOOT: begin
            level_q <= smp_i;
            state_q <= FLT_STEADY;
          end
          FLT_STEADY: begin
            if (smp_i != level_q) state_q <= FLT_SUSPECT;
          end
          FLT_SUSPECT: begin
            if (smp_i != level_q) begin
              level_q   <= smp_i;
              confirm_q <= 1'b1;
            end
            state_q <= FLT_STEADY;
          end
          default: state_q <= FLT_BOOT;
        endcase
      end
    end
  end

  assign level_o   = level_q;
  assign confirm_o = confirm_q;

  a_r2_level_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> $past(tick_i));
  a_r4_confirm_after_suspect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    confirm_q |-> $past(state_q == FLT_SUSPECT));
  a_r3_boot_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == FLT_BOOT)) |-> !confirm_q);
endmodule

// File: rtl/mlw_report.sv
`timescale 1ns/1ps
module mlw_report #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [N-1:0]     confirm_i,
  input  logic [N-1:0]     level_i,
  output logic             evt_valid_o,
  output logic [IDX_W-1:0] evt_idx_o,
  output logic             evt_level_o
);
  logic [N-1:0]     pend_q, pend_n, clr;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic             evt_valid_q, evt_level_q;
  logic [IDX_W-1:0] evt_idx_q;

  // lowest line number wins
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    clr = '0;
    if (pick_vld) clr[pick_idx] = 1'b1;
    pend_n = en_i ? ((pend_q & ~clr) | confirm_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      evt_valid_q <= 1'b0;
      evt_idx_q   <= '0;
      evt_level_q <= 1'b0;
    end else begin
      pend_q      <= pend_n;
      evt_valid_q <= pick_vld && en_i;
      evt_idx_q   <= pick_idx;
      evt_level_q <= level_i[pick_idx];
    end
  end

  assign evt_valid_o = evt_valid_q;
  assign evt_idx_o   = evt_idx_q;
  assign evt_level_o = evt_level_q;

  a_r8_no_event_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_q |-> $past(en_i));
  a_r6_index_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_q |-> (int'(evt_idx_q) < N));
  a_r7_queue_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q != '0) && $past(en_i) && en_i) |-> evt_valid_q);
endmodule

// File: rtl/modem_line_watch.sv
`timescale 1ns/1ps
module modem_line_watch #(
  parameter int NUM_LINES = 3,
  parameter int CNT_W     = 17,
  parameter int IDX_W     = mlw_pkg::idx_width(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [CNT_W-1:0]     tick_div_i,
  input  logic                 report_en_i,
  input  logic                 rd_req_i,
  output logic                 rd_valid_o,
  output logic [NUM_LINES-1:0] rd_level_o,
  output logic                 evt_valid_o,
  output logic [IDX_W-1:0]     evt_idx_o,
  output logic                 evt_level_o
);
  logic [NUM_LINES-1:0] smp, level, confirm;
  logic                 tick;
  logic                 rd_valid_q;
  logic [NUM_LINES-1:0] rd_level_q;

  mlw_sync #(.W(NUM_LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(smp)
  );

  mlw_tick #(.CNT_W(CNT_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(tick_div_i), .tick_o(tick)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mlw_filter u_flt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .smp_i(smp[g]),
      .level_o(level[g]), .confirm_o(confirm[g])
    );
  end

  mlw_report #(.N(NUM_LINES), .IDX_W(IDX_W)) u_rep (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(report_en_i),
    .confirm_i(confirm), .level_i(level),
    .evt_valid_o(evt_valid_o), .evt_idx_o(evt_idx_o), .evt_level_o(evt_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_level_q <= '0;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rd_level_q <= level;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_level_o = rd_level_q;

  a_r9_read_answers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
  a_r9_no_spurious_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);
  a_r6_event_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && $past(evt_valid_o)) |-> (evt_idx_o != $past(evt_idx_o)));
endmodule

// File: tb/modem_line_watch_tb_top.sv
`timescale 1ns/1ps
module modem_line_watch_tb_top;
  localparam int N     = 3;
  localparam int CW    = 17;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  line = 3'b010;
  logic [CW-1:0] div = CW'(19);
  logic          en = 1'b1;
  logic          rd_req = 1'b0;
  logic          rd_valid, evt_valid, evt_level;
  logic [N-1:0]  rd_level;
  logic [IW-1:0] evt_idx;

  int total = 0;
  int bad = 0;
  int ev_seen = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  modem_line_watch #(.NUM_LINES(N), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tick_div_i(div),
    .report_en_i(en), .rd_req_i(rd_req), .rd_valid_o(rd_valid),
    .rd_level_o(rd_level), .evt_valid_o(evt_valid), .evt_idx_o(evt_idx),
    .evt_level_o(evt_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor: expected item encodes idx*2+level
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      ev_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected event", int'(evt_idx) * 2 + int'(evt_level), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check((int'(evt_idx) * 2 + int'(evt_level)) == e, "R6/R7 event idx*2+level",
              int'(evt_idx) * 2 + int'(evt_level), e);
      end
    end
  end

  task automatic do_read(input logic [N-1:0] exp, input string req);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_valid == 1'b1, "R9 read strobe", int'(rd_valid), 1);
    check(rd_level == exp, req, int'(rd_level), int'(exp));
    @(negedge clk);
    check(rd_valid == 1'b0, "R9 strobe one cycle", int'(rd_valid), 0);
  endtask

  task automatic run_all();
    int base;
    cyc(3);
    check(evt_valid == 1'b0, "R1 evt in reset", int'(evt_valid), 0);
    check(rd_valid == 1'b0, "R1 rd in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    cyc(2);
    do_read(3'b000, "R1 levels before first tick");
    cyc(30);
    do_read(3'b010, "R3 boot load");
    check(ev_seen == 0, "R3 no boot event", ev_seen, 0);

    // R4: lasting change on line 0
    base = ev_seen;
    line[0] = 1'b1;
    exp_q.push_back(0 * 2 + 1);
    cyc(22);
    check(ev_seen == base, "R4 not after one sample", ev_seen, base);
    cyc(28);
    check(ev_seen == base + 1, "R4 confirmed after two", ev_seen, base + 1);
    do_read(3'b011, "R4 level updated");

    // R5: one-period pulse on line 2
    base = ev_seen;
    line[2] = 1'b1;
    cyc(20);
    line[2] = 1'b0;
    cyc(60);
    check(ev_seen == base, "R5 glitch rejected", ev_seen, base);
    do_read(3'b011, "R5 level kept");

    // R7: two lines at once
    base = ev_seen;
    line[1] = 1'b0;
    line[2] = 1'b1;
    exp_q.push_back(1 * 2 + 0);
    exp_q.push_back(2 * 2 + 1);
    cyc(50);
    check(ev_seen == base + 2, "R7 both reported", ev_seen, base + 2);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    do_read(3'b101, "R7 levels");

    // R8: reporting disabled
    base = ev_seen;
    en = 1'b0;
    line[0] = 1'b0;
    cyc(50);
    check(ev_seen == base, "R8 silent when off", ev_seen, base);
    do_read(3'b100, "R9 read while off");
    en = 1'b1;
    cyc(50);
    check(ev_seen == base, "R8 no replay", ev_seen, base);

    // R2: shorter tick period
    div = CW'(4);
    cyc(12);
    base = ev_seen;
    line[0] = 1'b1;
    exp_q.push_back(0 * 2 + 1);
    cyc(17);
    check(ev_seen == base + 1, "R2 fast tick confirms sooner", ev_seen, base + 1);
    do_read(3'b101, "R2 level after fast tick");
    check(exp_q.size() == 0, "R6 no missing events", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        cyc(200000);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule